// File: doc/BRIEF.md
# Reset and Sleep-Wake Controller

This block merges every reset source of a small 8-bit microcontroller into a single core reset pulse. It also produces the strobes that act on state outside the block: clearing the program counter, clearing the watchdog counter and its prescaler, disabling the watchdog, and presetting the control register to 0xFF. A separate flag is high during power-on resets only, so the register file can clear the status bits that only a power-on may touch. A 2-bit code records which source started the last reset.

The block also owns the low-power sleep state. When the core executes its sleep instruction with the keep-awake control bit at 0, the block raises a clock-stop signal for the CPU and crystal. Any wake event ends sleep with a full reset, so execution always restarts at address zero. The external reset pin is asynchronous and passes through a two-flop synchronizer. The core reset is held for a fixed number of cycles after the last active request has gone away.

Top module: `rst_wake_ctrl`

## Requirements
- R1: While `rst_ni` is low, or one cycle after `por_i` is high, `core_rst_o` is 1, `cause_o` is 2'b00 (power-on) and `por_flag_o` is 1.
- R2: While awake, a watchdog timeout starts a reset with cause 2'b01 only when `wdt_en_i` is 1 and `run_mode_i` is 2'b00 (eco) or 2'b01 (full). In modes 2'b10 and 2'b11, or with the watchdog disabled, the timeout is ignored.
- R3: `ext_rst_ni` low passes two synchronizer flops before it acts. A pin reset gives cause 2'b10.
- R4: `core_rst_o` rises on the clock edge that follows a request. It stays high for exactly STRETCH (default 4) edges after the last cycle in which any request was present.
- R5: `pc_clr_o`, `wdt_clr_o`, `wdt_dis_o` and `ctl_preset_o` are high in every cycle of the reset pulse and low outside it.
- R6: `por_flag_o` is high only during a reset pulse whose cause is 2'b00.
- R7: A one-cycle `sleep_req_i` with `keep_awake_i` at 0, given outside a reset pulse, sets `clk_stop_o` on the next edge. A sleep request given during a reset pulse is ignored.
- R8: A sleep request with `keep_awake_i` at 1 is ignored: `clk_stop_o` and `core_rst_o` stay 0.
- R9: While asleep, any of the following ends sleep with a full reset of cause 2'b11 and clears `clk_stop_o`: `ext_irq_i`, a synchronized pin-low, or a watchdog timeout with `wdt_en_i` at 1 in any run mode. A watchdog timeout with the watchdog disabled leaves the block asleep.
- R10: `ext_irq_i` while awake has no effect on `core_rst_o` or `clk_stop_o`.
- R11: Requests present in the same cycle are ranked power-on > wake > pin > watchdog. During a pulse, `cause_o` changes only to a higher-ranked cause, and it holds while no request is present.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; behaves as power-on |
| por_i | input | 1 | Power-on detect level |
| wdt_timeout_i | input | 1 | Watchdog timeout strobe |
| wdt_en_i | input | 1 | Watchdog enable |
| run_mode_i | input | 2 | Run mode: 00 eco, 01 full, 10 slow, 11 idle |
| ext_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| ext_irq_i | input | 1 | External interrupt line |
| sleep_req_i | input | 1 | Sleep instruction strobe |
| keep_awake_i | input | 1 | Control bit; 1 blocks sleep |
| core_rst_o | output | 1 | Core reset pulse |
| por_flag_o | output | 1 | Power-on reset in progress |
| pc_clr_o | output | 1 | Program counter clear |
| wdt_clr_o | output | 1 | Watchdog counter and prescaler clear |
| wdt_dis_o | output | 1 | Watchdog disable |
| ctl_preset_o | output | 1 | Control register preset to 0xFF |
| clk_stop_o | output | 1 | Stop CPU clock and crystal (sleep) |
| cause_o | output | 2 | Last reset cause: 00 power-on, 01 watchdog, 10 pin, 11 wake |

## Verification
The assertions check the following on every cycle:
- a request raises the reset on the following edge;
- a power-on always yields cause 00 with the flag set;
- a disabled watchdog cannot reset an awake core;
- a blocked sleep request leaves the clock running;
- an interrupt during sleep wakes the core with cause 11;
- the cause holds while no request is present.

Only the bench scenarios can show the exact pulse lengths, the two-cycle synchronizer latency of the pin, and the upgrade of the cause when a pin request arrives inside a watchdog pulse. The same holds for the mode gating of the watchdog across all four modes and for a sleep request that is dropped during a reset pulse.

// File: rtl/rswk_pkg.sv
package rswk_pkg;
  typedef enum logic [1:0] {
    CAUSE_POR  = 2'b00,
    CAUSE_WDT  = 2'b01,
    CAUSE_PIN  = 2'b10,
    CAUSE_WAKE = 2'b11
  } cause_e;

  localparam logic [1:0] MODE_ECO  = 2'b00;
  localparam logic [1:0] MODE_FULL = 2'b01;
  localparam logic [1:0] MODE_SLOW = 2'b10;
  localparam logic [1:0] MODE_IDLE = 2'b11;

  // lower rank wins
  function automatic logic [1:0] cause_rank(cause_e c);
    case (c)
      CAUSE_POR:  return 2'd0;
      CAUSE_WAKE: return 2'd1;
      CAUSE_PIN:  return 2'd2;
      default:    return 2'd3;
    endcase
  endfunction
endpackage

// File: rtl/rswk_sync.sv
module rswk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= RST_VAL;
        else         ff_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rswk_src.sv
module rswk_src
  import rswk_pkg::*;
(
  input  logic       por_i,
  input  logic       wdt_timeout_i,
  input  logic       wdt_en_i,
  input  logic [1:0] run_mode_i,
  input  logic       pin_low_i,
  input  logic       ext_irq_i,
  input  logic       asleep_i,
  output logic       req_o,
  output cause_e     cause_o
);
  logic mode_ok, wdt_run, wake;

  always_comb begin
    case (run_mode_i)
      MODE_ECO, MODE_FULL:  mode_ok = 1'b1;
      MODE_SLOW, MODE_IDLE: mode_ok = 1'b0;
      default:              mode_ok = 1'b0;
    endcase
  end

  assign wdt_run = wdt_timeout_i && wdt_en_i && mode_ok && !asleep_i;
  assign wake    = asleep_i && (ext_irq_i || pin_low_i || (wdt_timeout_i && wdt_en_i));
  assign req_o   = por_i || wake || pin_low_i || wdt_run;

  always_comb begin
    if (por_i)          cause_o = CAUSE_POR;
    else if (wake)      cause_o = CAUSE_WAKE;
    else if (pin_low_i) cause_o = CAUSE_PIN;
    else                cause_o = CAUSE_WDT;
  end
endmodule

// File: rtl/rswk_stretch.sv
module rswk_stretch
  import rswk_pkg::*;
#(
  parameter int STRETCH = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   req_i,
  input  cause_e cause_i,
  output logic   active_o,
  output cause_e cause_o
);
  localparam int CW = $clog2(STRETCH + 1);

  logic [CW-1:0] cnt_q;
  cause_e        cause_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= CW'(STRETCH);
      cause_q <= CAUSE_POR;
    end else begin
      if (req_i)               cnt_q <= CW'(STRETCH);
      else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
      // new pulse takes any cause; running pulse only upgrades
      if (req_i && (cnt_q == '0 || cause_rank(cause_i) < cause_rank(cause_q)))
        cause_q <= cause_i;
    end
  end

  assign active_o = (cnt_q != '0);
  assign cause_o  = cause_q;
endmodule

// File: rtl/rswk_sleep.sv
module rswk_sleep (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic keep_awake_i,
  input  logic rst_busy_i,
  input  logic req_i,
  output logic asleep_o
);
  logic asleep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          asleep_q <= 1'b0;
    else if (req_i)                                       asleep_q <= 1'b0;
    else if (sleep_req_i && !keep_awake_i && !rst_busy_i) asleep_q <= 1'b1;
  end

  assign asleep_o = asleep_q;
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
  import rswk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH     = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       por_i,
  input  logic       wdt_timeout_i,
  input  logic       wdt_en_i,
  input  logic [1:0] run_mode_i,
  input  logic       ext_rst_ni,
  input  logic       ext_irq_i,
  input  logic       sleep_req_i,
  input  logic       keep_awake_i,
  output logic       core_rst_o,
  output logic       por_flag_o,
  output logic       pc_clr_o,
  output logic       wdt_clr_o,
  output logic       wdt_dis_o,
  output logic       ctl_preset_o,
  output logic       clk_stop_o,
  output logic [1:0] cause_o
);
  logic   pin_sync, pin_low, any_req, asleep, active;
  cause_e req_cause, cur_cause;

  rswk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ext_rst_ni), .q_o(pin_sync)
  );
  assign pin_low = !pin_sync;

  rswk_src u_src (
    .por_i(por_i), .wdt_timeout_i(wdt_timeout_i), .wdt_en_i(wdt_en_i),
    .run_mode_i(run_mode_i), .pin_low_i(pin_low), .ext_irq_i(ext_irq_i),
    .asleep_i(asleep), .req_o(any_req), .cause_o(req_cause)
  );

  rswk_stretch #(.STRETCH(STRETCH)) u_stretch (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(any_req), .cause_i(req_cause),
    .active_o(active), .cause_o(cur_cause)
  );

  rswk_sleep u_sleep (
    .clk_i(clk_i), .rst_ni(rst_ni), .sleep_req_i(sleep_req_i),
    .keep_awake_i(keep_awake_i), .rst_busy_i(active), .req_i(any_req),
    .asleep_o(asleep)
  );

  assign core_rst_o   = active;
  assign pc_clr_o     = active;
  assign wdt_clr_o    = active;
  assign wdt_dis_o    = active;
  assign ctl_preset_o = active;
  assign por_flag_o   = active && (cur_cause == CAUSE_POR);
  assign clk_stop_o   = asleep;
  assign cause_o      = cur_cause;
endmodule

// File: rtl/rswk_chk.sv
module rswk_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       wdt_timeout_i,
  input logic       wdt_en_i,
  input logic       ext_irq_i,
  input logic       sleep_req_i,
  input logic       keep_awake_i,
  input logic       core_rst_o,
  input logic       por_flag_o,
  input logic       clk_stop_o,
  input logic [1:0] cause_o,
  input logic       any_req,
  input logic       pin_low
);
  p_por_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (core_rst_o && cause_o == 2'b00 && por_flag_o));

  p_wdt_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_timeout_i && !wdt_en_i && !clk_stop_o && !por_i && !pin_low && !core_rst_o)
    |=> !core_rst_o);

  p_req_starts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |=> core_rst_o);

  p_sleep_clean_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stop_o |-> !core_rst_o);

  p_keep_awake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && keep_awake_i && !clk_stop_o) |=> !clk_stop_o);

  p_wake_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_stop_o && ext_irq_i && !por_i) |=> (core_rst_o && cause_o == 2'b11 && !clk_stop_o));

  p_cause_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_rst_o && !any_req) |=> $stable(cause_o));
endmodule

bind rst_wake_ctrl rswk_chk u_chk (.*);

// File: tb/rst_wake_ctrl_test.sv
module rst_wake_ctrl_test;
  logic clk = 1'b0;
  logic rst_n, por, wdt, wen, ext_rst_n, irq, sleep, keep;
  logic [1:0] mode;
  logic core_rst, por_flag, pc_clr, wdt_clr, wdt_dis, ctl_preset, clk_stop;
  logic [1:0] cause;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rst_wake_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .wdt_timeout_i(wdt), .wdt_en_i(wen),
    .run_mode_i(mode), .ext_rst_ni(ext_rst_n), .ext_irq_i(irq), .sleep_req_i(sleep),
    .keep_awake_i(keep), .core_rst_o(core_rst), .por_flag_o(por_flag), .pc_clr_o(pc_clr),
    .wdt_clr_o(wdt_clr), .wdt_dis_o(wdt_dis), .ctl_preset_o(ctl_preset),
    .clk_stop_o(clk_stop), .cause_o(cause)
  );

  // [15]sleep [14]por [13]wdt [12]pin [11]irq [10]wen [9:8]mode [7]fire [6:5]cause [4:0]len
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'b0_0_1_0_0_1_00_1_01_00100, // R2 eco
    16'b0_0_1_0_0_1_01_1_01_00100, // R2 full
    16'b0_0_1_0_0_1_10_0_00_00000, // R2 slow ignored
    16'b0_0_1_0_0_1_11_0_00_00000, // R2 idle ignored
    16'b0_0_1_0_0_0_00_0_00_00000, // R2 disabled
    16'b0_0_0_1_0_0_00_1_10_00100, // R3 pin
    16'b0_1_0_0_0_0_00_1_00_00100, // R1 por
    16'b0_0_0_0_1_0_00_0_00_00000, // R10 irq awake
    16'b1_0_0_0_1_0_00_1_11_00100, // R9 irq wake
    16'b1_0_1_0_0_1_10_1_11_00100, // R9 wdt wake any mode
    16'b1_0_0_1_0_0_00_1_11_00100, // R9 pin wake
    16'b0_1_1_0_0_1_00_1_00_00100, // R11 por beats wdt
    16'b0_0_1_1_0_1_00_1_10_00110, // R11 pin upgrades wdt pulse
    16'b1_1_0_0_1_0_00_1_00_00100, // R11 por beats wake
    16'b1_0_1_0_0_0_00_0_00_00000  // R9 disabled wdt stays asleep
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int n;
    int c;
    logic [15:0] v;
    rst_n = 1'b0; por = 0; wdt = 0; wen = 0; ext_rst_n = 1; irq = 0;
    sleep = 0; keep = 0; mode = 2'b00;
    repeat (3) @(negedge clk);
    chk(core_rst == 1'b1, "R1 rst core_rst", int'(core_rst), 1);
    chk(cause == 2'b00, "R1 rst cause", int'(cause), 0);
    chk(por_flag == 1'b1, "R1 rst por_flag", int'(por_flag), 1);
    chk(clk_stop == 1'b0, "R1 rst clk_stop", int'(clk_stop), 0);
    chk({pc_clr, wdt_clr, wdt_dis, ctl_preset} == 4'hF, "R5 rst strobes",
        int'({pc_clr, wdt_clr, wdt_dis, ctl_preset}), 15);
    rst_n = 1'b1;
    n = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (core_rst) n++;
    end
    chk(n == 3, "R4 stretch after rst release", n, 3);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      wen = v[10]; mode = v[9:8]; keep = 1'b0;
      if (v[15]) begin
        sleep = 1'b1;
        @(negedge clk);
        sleep = 1'b0;
        chk(clk_stop == 1'b1, "R7 sleep entry", int'(clk_stop), 1);
      end
      por = v[14]; wdt = v[13]; ext_rst_n = ~v[12]; irq = v[11];
      @(negedge clk);
      por = 0; wdt = 0; ext_rst_n = 1; irq = 0;
      n = 0; c = -1;
      for (int k = 0; k < 12; k++) begin
        if (core_rst) begin
          n++;
          c = int'(cause);
          chk(por_flag == (cause == 2'b00), "R6 por_flag", int'(por_flag), int'(cause == 2'b00));
          chk({pc_clr, wdt_clr, wdt_dis, ctl_preset} == 4'hF, "R5 strobes high",
              int'({pc_clr, wdt_clr, wdt_dis, ctl_preset}), 15);
        end else begin
          chk({pc_clr, wdt_clr, wdt_dis, ctl_preset, por_flag} == 5'h0, "R5 strobes low",
              int'({pc_clr, wdt_clr, wdt_dis, ctl_preset, por_flag}), 0);
        end
        @(negedge clk);
      end
      if (v[7]) begin
        chk(n == int'(v[4:0]), $sformatf("R4 pulse len vec%0d", i), n, int'(v[4:0]));
        chk(c == int'(v[6:5]), $sformatf("R11 cause vec%0d", i), c, int'(v[6:5]));
      end else begin
        chk(n == 0, $sformatf("R2/R10 no reset vec%0d", i), n, 0);
      end
      chk(clk_stop == (v[15] && !v[7]), $sformatf("R9 clk_stop after vec%0d", i),
          int'(clk_stop), int'(v[15] && !v[7]));
    end

    // still asleep from last vector: wake by interrupt
    irq = 1'b1;
    @(negedge clk);
    irq = 1'b0;
    chk(core_rst == 1'b1 && cause == 2'b11, "R9 irq wake cause", int'(cause), 3);
    repeat (8) @(negedge clk);
    chk(clk_stop == 1'b0, "R9 awake after wake", int'(clk_stop), 0);

    // R8 blocked sleep
    keep = 1'b1; sleep = 1'b1;
    @(negedge clk);
    sleep = 1'b0; keep = 1'b0;
    chk(clk_stop == 1'b0, "R8 keep_awake clk_stop", int'(clk_stop), 0);
    chk(core_rst == 1'b0, "R8 keep_awake core_rst", int'(core_rst), 0);

    // R7 sleep request inside a reset pulse is dropped
    wen = 1'b1; mode = 2'b00; wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0; sleep = 1'b1;
    @(negedge clk);
    sleep = 1'b0;
    repeat (8) @(negedge clk);
    chk(clk_stop == 1'b0, "R7 sleep during reset ignored", int'(clk_stop), 0);
    chk(core_rst == 1'b0, "R4 pulse ended", int'(core_rst), 0);

    finish_run();
  end
endmodule